// File: doc/BRIEF.md
# Programmable Logic Block with Input Switch Matrix

This block is the combinational core of one logic block inside a small programmable logic device. A switch matrix looks at a global bus and picks a fixed number of signals from it for the block. The bus holds the dedicated input pins, the I/O pin signals and the buried feedback from every macrocell in the device. Each pick is made by its own select index, and an index that points past the end of the bus yields a constant 0.

The picked signals feed product terms. There are five per macrocell, and each one is an AND over the picked signals. Every literal in a term is configured as true, complement, ignored or forcing. Each macrocell also drives one foldback signal, which is the inverse of one of its own terms chosen by configuration. Foldbacks are shared inside a region of four macrocells. A macrocell's output is the OR of its five local terms and whichever regional foldbacks it enables, so it can form a sum of up to nine terms. Flip-flops, pads and any fitting step lie outside this block. The outputs are the raw sum-of-products values, the foldback bus and the picked block signals.

Top module: `pld_logic_block`

## Requirements
- R1: The global bus is ordered with the dedicated pins at indices 0 to N_PIN-1, then the I/O pins, then the buried feedback lines. Select field j (bits j*SEL_W upward of the select vector) drives block signal j with the bus bit at its index.
- R2: A select index equal to or greater than the bus width drives block signal j to 0.
- R3: Each literal of a product term has a 2-bit code: 00 ignores the signal, 01 uses it true and 10 uses it complemented. A term whose literals all read 00 evaluates to 1.
- R4: Literal code 11 forces its whole product term to 0, whatever the signal values are.
- R5: The foldback of a macrocell is the inverse of the local term its pick field names (0 to 4). A pick value of 5 or more makes the foldback 0.
- R6: A macrocell output is 1 exactly when one of its five local terms is 1 or an enabled regional foldback is 1. Enable bit k of macrocell m selects the foldback of macrocell 4*(m/4)+k.
- R7: A foldback whose enable bit is clear has no effect on the macrocell output, and foldbacks from other regions never reach it.
- R8: One macrocell can combine five local terms and four regional foldbacks, its own foldback included, so that each of nine terms alone sets its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pin_in | input | N_PIN | Dedicated input pin levels |
| io_in | input | N_IO | I/O pin levels |
| fb_in | input | N_FB | Buried macrocell feedback from the whole device |
| sel_cfg | input | N_SEL*SEL_W | Select index for each switch-matrix output |
| pt_cfg | input | N_MC*N_PT*N_SEL*2 | Literal codes, per macrocell, term and block signal |
| fbk_pick | input | N_MC*PICK_W | Term that is inverted onto each foldback |
| fbk_en | input | N_MC*REGION | Regional foldback enables per macrocell |
| blk_sig | output | N_SEL | Signals picked by the switch matrix |
| fbk_bus | output | N_MC | Foldback value of each macrocell |
| sum_out | output | N_MC | Sum-of-products output per macrocell |

## Verification
The bench uses the default sizes: 4 pins, 32 I/O pins, 32 feedback lines, 40 picks, 16 macrocells, five terms each and regions of four. With these sizes the bus is 68 wide and the select field is 7 bits, which leaves indices 68 to 127 for the out-of-range case. The 16 macrocells form four regions, so the bench can probe both foldback sharing inside a region and isolation between regions. Five local terms plus four foldbacks make the nine-term walk possible on a single macrocell.

// File: rtl/pld_lb_pkg.sv
// Shared encodings for the programmable logic block.
// Assumes each literal of a product term is configured by a 2-bit code.
package pld_lb_pkg;

    typedef enum logic [1:0] {
        LIT_DC   = 2'b00,
        LIT_TRUE = 2'b01,
        LIT_COMP = 2'b10,
        LIT_KILL = 2'b11
    } lit_mode_e;

    // Contribution of one literal to an AND term.
    function automatic logic lit_pass(input logic [1:0] mode, input logic x);
        case (lit_mode_e'(mode))
            LIT_DC:   return 1'b1;
            LIT_TRUE: return x;
            LIT_COMP: return !x;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lb_switch_matrix.sv
// Switch matrix: each output takes one global-bus bit chosen by its own index.
// Assumes SEL_W is wide enough to address every bus bit; larger indices give 0.
module lb_switch_matrix #(
    parameter int GB    = 68,
    parameter int N_SEL = 40,
    parameter int SEL_W = 7
) (
    input  logic [GB-1:0]          gbus,
    input  logic [N_SEL*SEL_W-1:0] sel_cfg,
    output logic [N_SEL-1:0]       blk_sig
);

    for (genvar j = 0; j < N_SEL; j++) begin : g_pick
        logic [SEL_W-1:0] idx;
        assign idx = sel_cfg[j*SEL_W +: SEL_W];

        // Route the indexed bus bit, or 0 when the index is out of range.
        always_comb begin
            if (int'(idx) < GB) blk_sig[j] = gbus[idx];
            else                blk_sig[j] = 1'b0;
        end
    end

endmodule

// File: rtl/lb_pterm.sv
// One product term: AND over all block signals, each through its literal code.
// Assumes lit_cfg holds one 2-bit code per block signal, signal 0 lowest.
module lb_pterm
    import pld_lb_pkg::*;
#(
    parameter int N_SEL = 40
) (
    input  logic [N_SEL-1:0]   blk_sig,
    input  logic [2*N_SEL-1:0] lit_cfg,
    output logic               term
);

    // Fold every literal into the AND; an all-ignore term stays 1.
    always_comb begin
        term = 1'b1;
        for (int j = 0; j < N_SEL; j++) begin
            term = term & lit_pass(lit_cfg[2*j +: 2], blk_sig[j]);
        end
    end

endmodule

// File: rtl/lb_macro_sum.sv
// Macrocell sum: ORs local terms with enabled regional foldbacks and
// produces this macrocell's own inverted foldback term.
// Assumes the region vector is ordered by macrocell position in the region.
module lb_macro_sum #(
    parameter int N_PT   = 5,
    parameter int REGION = 4,
    parameter int PICK_W = 3
) (
    input  logic [N_PT-1:0]   pt,
    input  logic [PICK_W-1:0] pick,
    input  logic [REGION-1:0] fb_region,
    input  logic [REGION-1:0] fb_en,
    output logic              fbk,
    output logic              sum
);

    // Invert the picked local term; an invalid pick idles the foldback at 0.
    always_comb begin
        if (int'(pick) < N_PT) fbk = !pt[pick];
        else                   fbk = 1'b0;
    end

    // Wide OR of local terms and the enabled shared foldbacks.
    always_comb begin
        sum = (|pt) | (|(fb_region & fb_en));
    end

endmodule

// File: rtl/pld_logic_block.sv
// Logic block top: global bus, switch matrix, product-term array and
// per-macrocell sums with regional foldback sharing. Purely combinational.
// Assumes N_MC is a whole multiple of REGION.
module pld_logic_block #(
    parameter int N_PIN  = 4,
    parameter int N_IO   = 32,
    parameter int N_FB   = 32,
    parameter int N_SEL  = 40,
    parameter int N_MC   = 16,
    parameter int N_PT   = 5,
    parameter int REGION = 4,
    localparam int GB     = N_PIN + N_IO + N_FB,
    localparam int SEL_W  = $clog2(GB + 1),
    localparam int PICK_W = $clog2(N_PT + 1),
    localparam int PT_BITS = N_MC * N_PT * N_SEL * 2
) (
    input  logic [N_PIN-1:0]        pin_in,
    input  logic [N_IO-1:0]         io_in,
    input  logic [N_FB-1:0]         fb_in,
    input  logic [N_SEL*SEL_W-1:0]  sel_cfg,
    input  logic [PT_BITS-1:0]      pt_cfg,
    input  logic [N_MC*PICK_W-1:0]  fbk_pick,
    input  logic [N_MC*REGION-1:0]  fbk_en,
    output logic [N_SEL-1:0]        blk_sig,
    output logic [N_MC-1:0]         fbk_bus,
    output logic [N_MC-1:0]         sum_out
);

    logic [GB-1:0]                   gbus;
    logic [N_MC-1:0][N_PT-1:0]       pt_vec;

    // Assemble the global bus: pins lowest, then I/O, then buried feedback.
    assign gbus = {fb_in, io_in, pin_in};

    lb_switch_matrix #(
        .GB    (GB),
        .N_SEL (N_SEL),
        .SEL_W (SEL_W)
    ) u_swm (
        .gbus    (gbus),
        .sel_cfg (sel_cfg),
        .blk_sig (blk_sig)
    );

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        for (genvar t = 0; t < N_PT; t++) begin : g_pt
            lb_pterm #(
                .N_SEL (N_SEL)
            ) u_pt (
                .blk_sig (blk_sig),
                .lit_cfg (pt_cfg[((m*N_PT + t)*N_SEL)*2 +: 2*N_SEL]),
                .term    (pt_vec[m][t])
            );
        end

        lb_macro_sum #(
            .N_PT   (N_PT),
            .REGION (REGION),
            .PICK_W (PICK_W)
        ) u_sum (
            .pt        (pt_vec[m]),
            .pick      (fbk_pick[m*PICK_W +: PICK_W]),
            .fb_region (fbk_bus[(m/REGION)*REGION +: REGION]),
            .fb_en     (fbk_en[m*REGION +: REGION]),
            .fbk       (fbk_bus[m]),
            .sum       (sum_out[m])
        );
    end

endmodule

// File: rtl/lb_chk.sv
// Checker for the logic block: port-level rules on routing, foldback and sums.
// Assumes it is bound to pld_logic_block with matching parameters.
module lb_chk #(
    parameter int N_PIN  = 4,
    parameter int N_IO   = 32,
    parameter int N_FB   = 32,
    parameter int N_SEL  = 40,
    parameter int N_MC   = 16,
    parameter int N_PT   = 5,
    parameter int REGION = 4,
    localparam int GB     = N_PIN + N_IO + N_FB,
    localparam int SEL_W  = $clog2(GB + 1),
    localparam int PICK_W = $clog2(N_PT + 1),
    localparam int PT_BITS = N_MC * N_PT * N_SEL * 2
) (
    input logic [N_PIN-1:0]        pin_in,
    input logic [N_IO-1:0]         io_in,
    input logic [N_FB-1:0]         fb_in,
    input logic [N_SEL*SEL_W-1:0]  sel_cfg,
    input logic [PT_BITS-1:0]      pt_cfg,
    input logic [N_MC*PICK_W-1:0]  fbk_pick,
    input logic [N_MC*REGION-1:0]  fbk_en,
    input logic [N_SEL-1:0]        blk_sig,
    input logic [N_MC-1:0]         fbk_bus,
    input logic [N_MC-1:0]         sum_out
);

    logic [GB-1:0] bus_view;
    assign bus_view = {fb_in, io_in, pin_in};

    // Routing rules of the switch matrix.
    always_comb begin
        for (int j = 0; j < N_SEL; j++) begin
            AST_SEL_ROUTE: assert (int'(sel_cfg[j*SEL_W +: SEL_W]) >= GB || blk_sig[j] == bus_view[sel_cfg[j*SEL_W +: SEL_W]]); // R1
            AST_SEL_OOR: assert (int'(sel_cfg[j*SEL_W +: SEL_W]) < GB || !blk_sig[j]); // R2
        end
    end

    // Term, foldback and sum rules per macrocell.
    always_comb begin
        for (int m = 0; m < N_MC; m++) begin
            AST_PT_OPEN: assert ((|pt_cfg[(m*N_PT)*N_SEL*2 +: N_SEL*2]) || sum_out[m]); // R3
            AST_FBK_IDLE: assert (int'(fbk_pick[m*PICK_W +: PICK_W]) < N_PT || !fbk_bus[m]); // R5
            for (int k = 0; k < REGION; k++) begin
                AST_FBK_FEEDS: assert (!(fbk_en[m*REGION + k] && fbk_bus[(m/REGION)*REGION + k]) || sum_out[m]); // R6
            end
        end
    end

endmodule

bind pld_logic_block lb_chk #(
    .N_PIN  (N_PIN),
    .N_IO   (N_IO),
    .N_FB   (N_FB),
    .N_SEL  (N_SEL),
    .N_MC   (N_MC),
    .N_PT   (N_PT),
    .REGION (REGION)
) u_chk (
    .pin_in   (pin_in),
    .io_in    (io_in),
    .fb_in    (fb_in),
    .sel_cfg  (sel_cfg),
    .pt_cfg   (pt_cfg),
    .fbk_pick (fbk_pick),
    .fbk_en   (fbk_en),
    .blk_sig  (blk_sig),
    .fbk_bus  (fbk_bus),
    .sum_out  (sum_out)
);

// File: tb/sim_pld_logic_block.sv
// Directed bench for pld_logic_block, one task per scenario, plus a
// behavioural reference used for randomised configurations.
module sim_pld_logic_block;

    localparam int N_PIN  = 4;
    localparam int N_IO   = 32;
    localparam int N_FB   = 32;
    localparam int N_SEL  = 40;
    localparam int N_MC   = 16;
    localparam int N_PT   = 5;
    localparam int REGION = 4;
    localparam int GB     = N_PIN + N_IO + N_FB;
    localparam int SEL_W  = $clog2(GB + 1);
    localparam int PICK_W = $clog2(N_PT + 1);
    localparam int PT_BITS = N_MC * N_PT * N_SEL * 2;

    logic clk;
    logic rst_n;
    int   n_chk;
    int   n_bad;
    bit   done;

    logic [N_PIN-1:0]        pin_in;
    logic [N_IO-1:0]         io_in;
    logic [N_FB-1:0]         fb_in;
    logic [N_SEL*SEL_W-1:0]  sel_cfg;
    logic [PT_BITS-1:0]      pt_cfg;
    logic [N_MC*PICK_W-1:0]  fbk_pick;
    logic [N_MC*REGION-1:0]  fbk_en;
    logic [N_SEL-1:0]        blk_sig;
    logic [N_MC-1:0]         fbk_bus;
    logic [N_MC-1:0]         sum_out;

    logic [N_SEL-1:0] e_blk;
    logic [N_MC-1:0]  e_fbk;
    logic [N_MC-1:0]  e_sum;

    pld_logic_block u0 (
        .pin_in   (pin_in),
        .io_in    (io_in),
        .fb_in    (fb_in),
        .sel_cfg  (sel_cfg),
        .pt_cfg   (pt_cfg),
        .fbk_pick (fbk_pick),
        .fbk_en   (fbk_en),
        .blk_sig  (blk_sig),
        .fbk_bus  (fbk_bus),
        .sum_out  (sum_out)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic set_sel(input int j, input int idx);
        sel_cfg[j*SEL_W +: SEL_W] = SEL_W'(idx);
    endtask

    task automatic set_lit(input int m, input int t, input int j, input logic [1:0] c);
        pt_cfg[((m*N_PT + t)*N_SEL + j)*2 +: 2] = c;
    endtask

    task automatic open_term(input int m, input int t);
        for (int j = 0; j < N_SEL; j++) set_lit(m, t, j, 2'b00);
    endtask

    task automatic set_pick(input int m, input int p);
        fbk_pick[m*PICK_W +: PICK_W] = PICK_W'(p);
    endtask

    task automatic all_picks(input int p);
        for (int m = 0; m < N_MC; m++) set_pick(m, p);
    endtask

    // Behavioural reference: routing, literal terms, foldbacks, sums.
    task automatic ref_eval();
        logic [GB-1:0] gb;
        logic [N_PT-1:0] pts [N_MC];
        gb = {fb_in, io_in, pin_in};
        for (int j = 0; j < N_SEL; j++) begin
            int idx = int'(sel_cfg[j*SEL_W +: SEL_W]);
            e_blk[j] = (idx < GB) ? gb[idx] : 1'b0;
        end
        for (int m = 0; m < N_MC; m++) begin
            for (int t = 0; t < N_PT; t++) begin
                logic v = 1'b1;
                for (int j = 0; j < N_SEL; j++) begin
                    logic [1:0] c = pt_cfg[((m*N_PT + t)*N_SEL + j)*2 +: 2];
                    if (c == 2'b11) v = 1'b0;
                    else if (c == 2'b01 && !e_blk[j]) v = 1'b0;
                    else if (c == 2'b10 && e_blk[j]) v = 1'b0;
                end
                pts[m][t] = v;
            end
            begin
                int p = int'(fbk_pick[m*PICK_W +: PICK_W]);
                e_fbk[m] = (p < N_PT) ? !pts[m][p] : 1'b0;
            end
        end
        for (int m = 0; m < N_MC; m++) begin
            logic s = |pts[m];
            for (int k = 0; k < REGION; k++)
                if (fbk_en[m*REGION + k] && e_fbk[(m/REGION)*REGION + k]) s = 1'b1;
            e_sum[m] = s;
        end
    endtask

    // All-zero configuration state.
    task automatic t_default();
        sel_cfg = '0; pt_cfg = '0; fbk_pick = '0; fbk_en = '0;
        pin_in = 4'b0001; io_in = '0; fb_in = '0;
        settle();
        check("R1 default picks pin 0", 64'(blk_sig), 64'({N_SEL{1'b1}}));
        check("R3 open terms give 1", 64'(sum_out), 64'({N_MC{1'b1}}));
        check("R5 foldback of open term", 64'(fbk_bus), 64'(0));
    endtask

    // Switch matrix routing across the bus sections.
    task automatic t_route();
        for (int j = 0; j < N_SEL; j++) set_sel(j, (j*5 + 1) % GB);
        set_sel(0, 0); set_sel(1, 3); set_sel(2, 4); set_sel(3, 35);
        set_sel(4, 36); set_sel(5, 67);
        for (int p = 0; p < 3; p++) begin
            logic [GB-1:0] gb;
            logic [N_SEL-1:0] exp;
            pin_in = 4'($urandom); io_in = $urandom; fb_in = $urandom;
            if (p == 1) begin pin_in = '1; io_in = '0; fb_in = '1; end
            gb = {fb_in, io_in, pin_in};
            for (int j = 0; j < N_SEL; j++) exp[j] = gb[int'(sel_cfg[j*SEL_W +: SEL_W])];
            settle();
            check("R1 routed bus bits", 64'(blk_sig), 64'(exp));
        end
    endtask

    // Out-of-range indices drive zero.
    task automatic t_oor();
        pin_in = '1; io_in = '1; fb_in = '1;
        for (int j = 0; j < N_SEL; j++) set_sel(j, GB + j);
        set_sel(N_SEL-1, (1 << SEL_W) - 1);
        settle();
        check("R2 out-of-range picks", 64'(blk_sig), 64'(0));
        set_sel(7, GB - 1);
        settle();
        check("R2 last valid index still routes", 64'(blk_sig), 64'(1) << 7);
    endtask

    // Literal codes on a single term of macrocell 2.
    task automatic t_literal();
        pt_cfg = '1; fbk_en = '0; all_picks(7);
        pin_in = '0; io_in = '0; fb_in = '0;
        set_sel(0, 0); set_sel(1, 1); set_sel(2, 2);
        open_term(2, 3);
        set_lit(2, 3, 0, 2'b01);
        set_lit(2, 3, 1, 2'b10);
        for (int v = 0; v < 4; v++) begin
            pin_in[0] = v[0]; pin_in[1] = v[1];
            settle();
            check("R3 true/complement literals", 64'(sum_out), 64'(v == 1) << 2);
        end
        pin_in = 4'b0111;
        set_lit(2, 3, 1, 2'b00);
        settle();
        check("R3 ignored literal", 64'(sum_out), 64'(1) << 2);
        set_lit(2, 3, 2, 2'b11);
        settle();
        check("R4 forcing literal kills term", 64'(sum_out), 64'(0));
    endtask

    // Foldback pick, idle pick, enable and region isolation.
    task automatic t_fold();
        pt_cfg = '1; fbk_en = '0; all_picks(7);
        pin_in = '0; io_in = '0; fb_in = '0;
        set_sel(7, 4);
        open_term(5, 2);
        set_lit(5, 2, 7, 2'b01);
        set_pick(5, 2);
        io_in[0] = 1'b1;
        settle();
        check("R5 foldback inverts picked term (term 1)", 64'(fbk_bus), 64'(0));
        io_in[0] = 1'b0;
        settle();
        check("R5 foldback inverts picked term (term 0)", 64'(fbk_bus), 64'(1) << 5);
        fbk_en[6*REGION + 1] = 1'b1;
        settle();
        check("R6 enabled neighbour foldback", 64'(sum_out), 64'(1) << 6);
        fbk_en[6*REGION + 1] = 1'b0;
        fbk_en[2*REGION + 1] = 1'b1;
        settle();
        check("R7 disabled and foreign-region foldback", 64'(sum_out), 64'(0));
        set_pick(5, 6);
        fbk_en[6*REGION + 1] = 1'b1;
        settle();
        check("R5 pick beyond last term idles foldback", 64'(fbk_bus), 64'(0));
        check("R7 idle foldback leaves sum at 0", 64'(sum_out), 64'(0));
    endtask

    // Nine-term sum on macrocell 8 (region 8..11).
    task automatic t_nine();
        pt_cfg = '1; fbk_en = '0; all_picks(7);
        pin_in = '0; io_in = '0; fb_in = '0;
        for (int j = 0; j < 8; j++) set_sel(j, 4 + j);
        for (int t = 0; t < N_PT; t++) begin
            open_term(8, t);
            set_lit(8, t, t, 2'b01);
        end
        for (int k = 1; k < 4; k++) begin
            open_term(8 + k, 0);
            set_lit(8 + k, 0, 4 + k, 2'b10);
            set_pick(8 + k, 0);
        end
        fbk_en[8*REGION +: REGION] = 4'b1110;
        settle();
        check("R8 all terms low", 64'(sum_out[8]), 64'(0));
        for (int j = 0; j < 8; j++) begin
            io_in = '0; io_in[j] = 1'b1;
            settle();
            check($sformatf("R8 single term %0d raises sum", j), 64'(sum_out[8]), 64'(1));
        end
        io_in = '0;
        set_pick(8, 4);
        fbk_en[8*REGION] = 1'b1;
        settle();
        check("R8 own foldback is ninth term", 64'(sum_out[8]), 64'(1));
        fbk_en[8*REGION] = 1'b0;
        settle();
        check("R7 own foldback disabled", 64'(sum_out[8]), 64'(0));
    endtask

    // Random configurations against the behavioural reference.
    task automatic t_random();
        for (int n = 0; n < 30; n++) begin
            for (int j = 0; j < N_SEL; j++) set_sel(j, $urandom_range(GB + 8, 0));
            for (int b = 0; b < PT_BITS/2; b++) begin
                int r = $urandom_range(99, 0);
                pt_cfg[2*b +: 2] = (r < 94) ? 2'b00 : (r < 97) ? 2'b01 : (r < 99) ? 2'b10 : 2'b11;
            end
            for (int m = 0; m < N_MC; m++) set_pick(m, $urandom_range(7, 0));
            fbk_en = {$urandom, $urandom};
            pin_in = 4'($urandom); io_in = $urandom; fb_in = $urandom;
            ref_eval();
            settle();
            check("R1 R2 random picks", 64'(blk_sig), 64'(e_blk));
            check("R5 random foldbacks", 64'(fbk_bus), 64'(e_fbk));
            check("R6 random sums", 64'(sum_out), 64'(e_sum));
        end
    endtask

    initial begin
        n_chk = 0; n_bad = 0; done = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_default();
        t_route();
        t_oor();
        t_literal();
        t_fold();
        t_nine();
        t_random();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule